// File: doc/BRIEF.md
# Send-on-Change Shortest-Path Node

This block is one processing element of a distributed single-source shortest-path computation. It holds the best distance it has been offered so far and accepts distance messages one per cycle on a valid/ready input. A message that brings the distance strictly down replaces the stored value. The node then announces the new value to each of its successors. Each announcement goes out as its own message on a valid/ready output and carries the successor's node number and the new distance plus that successor's link delay. A message that brings no improvement is consumed silently. Output traffic therefore follows the data, not a fixed schedule.

The successor list is a small local table that is written before operation starts. Each entry holds an enable bit, a destination node number and an 8-bit link delay. Enabled entries are announced in ascending entry order, and disabled entries are skipped. While announcements are pending, the input is not ready. An idle output tells an external controller that this node has nothing left to send. A source node is seeded by delivering a message of distance zero.

Top module: `sp_node`

## Requirements
- R1: After reset the stored distance `dist_o` is 16'hFFFF (infinity), `idle_o` and `in_ready_o` are 1, `out_valid_o` is 0, and every table entry is disabled.
- R2: An accepted input whose distance is strictly less than the stored distance replaces it, so `dist_o` always equals the minimum of 16'hFFFF and all distances accepted since reset.
- R3: An accepted input whose distance is greater than or equal to the stored distance is consumed, produces no output message and leaves `idle_o` high on the following cycle.
- R4: From the cycle after an improving input is accepted until its last announcement has been handed over, `in_ready_o` is 0.
- R5: After an improvement, the node emits exactly one message per enabled table entry, in ascending entry index order. Each message has `out_node_o` equal to the entry's node number and `out_dist_o` equal to the new distance plus the entry's link delay.
- R6: When the distance plus link delay exceeds 16'hFFFF, `out_dist_o` is 16'hFFFF.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle keeps `out_valid_o` at 1 and holds `out_node_o` and `out_dist_o` unchanged.
- R8: Disabled entries produce no message. An improvement with no enabled entries changes `dist_o`, emits nothing, and returns the node to idle.
- R9: `idle_o` is 1 exactly when no announcement sequence is pending, and `in_ready_o` equals `idle_o`.
- R10: An input of distance 0 seeds a source node: `dist_o` becomes 0 and each enabled successor receives exactly its link delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | 3 | Table entry index |
| cfg_en_i | input | 1 | Entry enable written |
| cfg_node_i | input | 8 | Successor node number written |
| cfg_delay_i | input | 8 | Link delay written |
| in_valid_i | input | 1 | Incoming distance valid |
| in_ready_o | output | 1 | Node can accept a distance |
| in_dist_i | input | 16 | Incoming distance |
| out_valid_o | output | 1 | Outgoing message valid |
| out_ready_i | input | 1 | Network accepts outgoing message |
| out_node_o | output | 8 | Destination successor node number |
| out_dist_o | output | 16 | Saturated distance for the successor |
| dist_o | output | 16 | Stored best distance |
| idle_o | output | 1 | No announcement sequence pending |

## Verification
The hardest situation to reach is an announcement sequence that is held by backpressure while the entry pointer has to walk past disabled entries, with the sums near the top of the range. Only in that situation do stall stability, skipping and saturation all act at once. The bench fills the table with disabled gaps. It drives `out_ready_i` from a pseudo-random pattern that stalls roughly one cycle in four. After a second reset it seeds a distance just below infinity, so most sums clip. A scoreboard queue fed by the driver's own model of the minimum checks each message's order and contents.

// File: rtl/sp_node_pkg.sv
package sp_node_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sp_sat_add.sv
module sp_sat_add #(
  parameter int unsigned A_W = 16,
  parameter int unsigned B_W = 8
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] sum_o
);
  logic [A_W:0] wide;

  always_comb begin
    wide  = {1'b0, a_i} + {{(A_W + 1 - B_W){1'b0}}, b_i};
    sum_o = wide[A_W] ? {A_W{1'b1}} : wide[A_W-1:0];
  end
endmodule

// File: rtl/sp_succ_table.sv
module sp_succ_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned NODE_W  = 8,
  parameter int unsigned DELAY_W = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_en_i,
  input  logic [NODE_W-1:0]  wr_node_i,
  input  logic [DELAY_W-1:0] wr_delay_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_en_o,
  output logic [NODE_W-1:0]  rd_node_o,
  output logic [DELAY_W-1:0] rd_delay_o
);
  logic [ENTRIES-1:0]              en_q;
  logic [ENTRIES-1:0][NODE_W-1:0]  node_q;
  logic [ENTRIES-1:0][DELAY_W-1:0] delay_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = we_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]    <= 1'b0;
        node_q[g]  <= '0;
        delay_q[g] <= '0;
      end else if (sel) begin
        en_q[g]    <= wr_en_i;
        node_q[g]  <= wr_node_i;
        delay_q[g] <= wr_delay_i;
      end
    end
  end

  assign rd_en_o    = en_q[rd_idx_i];
  assign rd_node_o  = node_q[rd_idx_i];
  assign rd_delay_o = delay_q[rd_idx_i];
endmodule

// File: rtl/sp_send_seq.sv
module sp_send_seq #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ent_en_i,
  input  logic             out_ready_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             out_valid_o,
  output logic             busy_o
);
  import sp_node_pkg::*;

  seq_state_e       state_q;
  logic [IDX_W-1:0] ptr_q;
  logic             step;
  logic             last;

  // an entry is passed when disabled or when its message is taken
  assign step = (state_q == SEQ_SEND) && (!ent_en_i || out_ready_i);
  assign last = (ptr_q == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start_i) begin
        state_q <= SEQ_SEND;
        ptr_q   <= '0;
      end
    end else if (step) begin
      if (last) state_q <= SEQ_IDLE;
      ptr_q <= last ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o       = ptr_q;
  assign busy_o      = (state_q == SEQ_SEND);
  assign out_valid_o = busy_o && ent_en_i;
endmodule

// File: rtl/sp_node.sv
module sp_node #(
  parameter int unsigned DIST_W   = 16,
  parameter int unsigned DELAY_W  = 8,
  parameter int unsigned NODE_W   = 8,
  parameter int unsigned MAX_SUCC = 8,
  localparam int unsigned IDX_W   = $clog2(MAX_SUCC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [NODE_W-1:0]  cfg_node_i,
  input  logic [DELAY_W-1:0] cfg_delay_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [DIST_W-1:0]  in_dist_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [NODE_W-1:0]  out_node_o,
  output logic [DIST_W-1:0]  out_dist_o,
  output logic [DIST_W-1:0]  dist_o,
  output logic               idle_o
);
  localparam logic [DIST_W-1:0] DistInf = {DIST_W{1'b1}};

  logic [DIST_W-1:0]  dist_q;
  logic               busy;
  logic               improve;
  logic [IDX_W-1:0]   ptr;
  logic               ent_en;
  logic [DELAY_W-1:0] ent_delay;

  assign in_ready_o = !busy;
  assign improve    = in_valid_i && in_ready_o && (in_dist_i < dist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dist_q <= DistInf;
    else if (improve) dist_q <= in_dist_i;
  end

  sp_succ_table #(
    .ENTRIES (MAX_SUCC),
    .NODE_W  (NODE_W),
    .DELAY_W (DELAY_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_en_i    (cfg_en_i),
    .wr_node_i  (cfg_node_i),
    .wr_delay_i (cfg_delay_i),
    .rd_idx_i   (ptr),
    .rd_en_o    (ent_en),
    .rd_node_o  (out_node_o),
    .rd_delay_o (ent_delay)
  );

  sp_send_seq #(
    .ENTRIES (MAX_SUCC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (improve),
    .ent_en_i    (ent_en),
    .out_ready_i (out_ready_i),
    .ptr_o       (ptr),
    .out_valid_o (out_valid_o),
    .busy_o      (busy)
  );

  sp_sat_add #(
    .A_W (DIST_W),
    .B_W (DELAY_W)
  ) u_add (
    .a_i   (dist_q),
    .b_i   (ent_delay),
    .sum_o (out_dist_o)
  );

  assign dist_o = dist_q;
  assign idle_o = !busy;
endmodule

// File: rtl/sp_node_chk.sv
module sp_node_chk #(
  parameter int unsigned DIST_W  = 16,
  parameter int unsigned NODE_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DIST_W-1:0] in_dist_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [NODE_W-1:0] out_node_o,
  input logic [DIST_W-1:0] out_dist_o,
  input logic [DIST_W-1:0] dist_o,
  input logic              idle_o
);
  // R2
  a_r2_dist_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dist_o <= $past(dist_o));

  // R2
  a_r2_take_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_dist_i < dist_o) |=> (dist_o == $past(in_dist_i)));

  a_r3_no_send_when_worse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_dist_i >= dist_o) |=> (idle_o && !out_valid_o));

  a_r4_block_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_dist_o >= dist_o));

  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_node_o) && $stable(out_dist_o)));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!out_valid_o && in_ready_o));
endmodule

bind sp_node sp_node_chk #(
  .DIST_W (DIST_W),
  .NODE_W (NODE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_dist_i   (in_dist_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_node_o  (out_node_o),
  .out_dist_o  (out_dist_o),
  .dist_o      (dist_o),
  .idle_o      (idle_o)
);

// File: tb/sp_node_bench.sv
module sp_node_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [7:0]  cfg_node_i = '0;
  logic [7:0]  cfg_delay_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] in_dist_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_node_o;
  logic [15:0] out_dist_o;
  logic [15:0] dist_o;
  logic        idle_o;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_dist;
  logic        m_en[8];
  logic [7:0]  m_node[8];
  logic [7:0]  m_delay[8];
  logic [23:0] exp_q[$];

  logic [7:0]  lfsr = 8'hA5;
  logic        stall_prev = 1'b0;
  logic [7:0]  stall_node;
  logic [15:0] stall_dist;

  always #5 clk = ~clk;

  sp_node u_sp_node (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_en_i(cfg_en_i),
    .cfg_node_i(cfg_node_i), .cfg_delay_i(cfg_delay_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_dist_i(in_dist_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_node_o(out_node_o), .out_dist_o(out_dist_o),
    .dist_o(dist_o), .idle_o(idle_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sat(input logic [15:0] d, input logic [7:0] w);
    int s;
    s = int'(d) + int'(w);
    return (s > 65535) ? 16'hFFFF : 16'(s);
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (stall_prev) begin
        check(out_valid_o && out_node_o == stall_node && out_dist_o == stall_dist,
              "R7", "stalled message held", int'(out_dist_o), int'(stall_dist));
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready_i = lfsr[0] | lfsr[1];
      stall_prev = out_valid_o && !out_ready_i;
      stall_node = out_node_o;
      stall_dist = out_dist_o;
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R8", "unexpected message", int'({out_node_o, out_dist_o}), 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check({out_node_o, out_dist_o} == e, "R5/R6", "message node,dist",
                int'({out_node_o, out_dist_o}), int'(e));
        end
      end
    end else begin
      stall_prev = 1'b0;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    exp_q.delete();
    m_dist = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin m_en[i] = 1'b0; m_node[i] = '0; m_delay[i] = '0; end
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int idx, input bit en, input logic [7:0] nd, input logic [7:0] dl);
    cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_en_i = en; cfg_node_i = nd; cfg_delay_i = dl;
    m_en[idx] = en; m_node[idx] = nd; m_delay[idx] = dl;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // driver: computes expected traffic and pushes it before driving
  task automatic send(input logic [15:0] d, input string req);
    bit imp;
    while (!in_ready_o) @(negedge clk);
    imp = d < m_dist;
    if (imp) begin
      m_dist = d;
      for (int i = 0; i < 8; i++)
        if (m_en[i]) exp_q.push_back({m_node[i], sat(d, m_delay[i])});
    end
    in_valid_i = 1'b1; in_dist_i = d;
    @(negedge clk);
    in_valid_i = 1'b0;
    if (imp) begin
      check(!idle_o, "R9", "idle low after improvement", int'(idle_o), 0);
      check(!in_ready_o, "R4", "ready low while sending", int'(in_ready_o), 0);
    end else begin
      check(idle_o, {req, " R3"}, "idle after worse input", int'(idle_o), 1);
    end
    while (!(idle_o && exp_q.size() == 0)) @(negedge clk);
    check(dist_o == m_dist, {req, " R2"}, "stored distance", int'(dist_o), int'(m_dist));
    check(in_ready_o == idle_o && idle_o, "R9", "ready equals idle at rest",
          int'(in_ready_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run hung", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(dist_o == 16'hFFFF, "R1", "dist after reset", int'(dist_o), 16'hFFFF);
    check(idle_o && in_ready_o, "R1", "idle/ready after reset", int'({idle_o, in_ready_o}), 3);
    check(!out_valid_o, "R1", "no output after reset", int'(out_valid_o), 0);

    // infinity itself is not an improvement
    send(16'hFFFF, "R1");

    cfg(0, 1'b1, 8'd10, 8'd3);
    cfg(1, 1'b0, 8'd11, 8'd9);
    cfg(2, 1'b1, 8'd20, 8'd0);
    cfg(3, 1'b1, 8'd30, 8'd255);
    cfg(7, 1'b1, 8'd70, 8'd1);

    send(16'd1000, "R5");
    send(16'd1000, "R3 equal");
    send(16'd2000, "R3 larger");
    send(16'hFFF0, "R3 large");
    send(16'd500, "R5 second");
    send(16'd499, "R5 third");
    send(16'd600, "R3 after");

    // saturation near infinity, then seed to zero
    do_reset();
    check(dist_o == 16'hFFFF, "R1", "dist after second reset", int'(dist_o), 16'hFFFF);
    cfg(0, 1'b1, 8'd10, 8'd3);
    cfg(2, 1'b1, 8'd20, 8'd0);
    cfg(3, 1'b1, 8'd30, 8'd255);
    cfg(5, 1'b1, 8'd50, 8'd2);
    cfg(7, 1'b1, 8'd70, 8'd1);
    send(16'hFFFE, "R6");
    send(16'hFF80, "R6 partial");
    send(16'd0, "R10");
    check(dist_o == 16'd0, "R10", "seeded distance", int'(dist_o), 0);
    send(16'd0, "R10 repeat");

    // empty table: improvement without traffic
    do_reset();
    send(16'd5, "R8");
    check(exp_q.size() == 0 && idle_o, "R8", "no traffic from empty table",
          int'(exp_q.size()), 0);
    cfg(6, 1'b1, 8'd66, 8'd4);
    send(16'd4, "R8 single");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule